// File: doc/BRIEF.md
# Clocked Serial Link Port with Flow Control

This block moves 8-bit words over a data-out line, a data-in line and one shared bit clock. Both ends of the link see the same clock. A mode register sets the port's clock role. As clock master, the port prescales its own system clock, divides it again by a programmable count, and drives the bit clock out. As clock slave, it resynchronises a bit clock that arrives from outside and follows its edges. Outgoing data changes after a falling clock edge. Incoming data is captured on a rising clock edge. The bit clock rests high between words.

A simple register bus reaches six byte registers: mode, control 0, control 1/status, divisor, transmit buffer and receive buffer. An optional flow-control pin follows the clock role. A master waits for an active-low clear-to-send input before it starts a word. A slave drives an active-low ready-to-receive output while its receive buffer has room. One control bit turns flow control off completely.

Register addresses: 0 mode, 1 control 0, 2 control 1/status, 3 divisor, 4 transmit buffer (write), 5 receive buffer (read).

Top module: `sync_serial_port`

## Requirements
- R1: Words move only while mode[2:0] = 3'b001 and mode[7] = 0. Mode bits 4 to 6 have no effect. In any other mode setting the bit clock stays high, data-out stays high and buffered transmit data is held.
- R2: After reset, control 1 reads 8'h22. Its fields are bit0 transmit enable, bit1 transmit buffer empty, bit2 receive enable, bit3 receive complete, bit4 overrun and bit5 shift register empty. Also after reset: the receive buffer reads 0, sclk_o, txd and rts_n are 1, and sclk_oe is 0.
- R3: As master (mode[3] = 0), each low and each high phase of the bit clock lasts (n+1)·4^s system clocks. Here n is the divisor register and s is control0[1:0]. A word has exactly 8 low phases, and the clock then rests high.
- R4: A master starts a word only when transmit enable is set and the transmit buffer is full. If flow control is on (control0[4] = 0) and the pin acts as clear-to-send (control0[2] = 0), cts_n must also be low. With control0[4] = 1, cts_n is ignored.
- R5: control0[5] = 0 sends and receives least significant bit first. control0[5] = 1 sends and receives most significant bit first.
- R6: With receive enable set, the data-in bit is captured on each rising bit-clock edge. After 8 edges the word goes to the receive buffer and receive complete is set.
- R7: rts_n is low exactly when the mode is valid, flow control is on, control0[2] = 1, receive enable is set and the receive buffer is empty. In every other case rts_n is high.
- R8: If a word completes while the receive buffer is still unread, the overrun flag sets and the buffer keeps its earlier word.
- R9: As slave (mode[3] = 1), the port does not drive the clock (sclk_oe = 0) and the divider settings have no effect. It shifts on the external clock's edges. With nothing to send, data-out stays high.
- R10: A write to the transmit buffer clears transmit-buffer-empty. The flag sets again when the word moves into the shift register. A read of the receive buffer clears receive complete.
- R11: Writing control 1 with receive enable at 0 clears the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the receive buffer consumes the word) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| sclk_i | input | 1 | External bit clock, used as slave |
| sclk_o | output | 1 | Generated bit clock, used as master |
| sclk_oe | output | 1 | High when the port drives the bit clock |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| cts_n | input | 1 | Active-low clear-to-send |
| rts_n | output | 1 | Active-low ready-to-receive |

## Verification
The assertions assume that software leaves the mode, control 0 and divisor registers alone while a word is moving. They also assume that an external bit clock holds each phase for several system clocks, longer than the input synchroniser, and that data-in stays stable around each rising edge. The stimulus follows these rules. It sets the registers up only while the port is idle. It drives the slave clock with 8-cycle phases. As master it changes data-in only just after a falling edge it has observed, and it pulses cts_n only between words.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_CTL0 = 3'd1,
    A_CTL1 = 3'd2,
    A_DIV  = 3'd3,
    A_TXB  = 3'd4,
    A_RXB  = 3'd5
  } ssp_addr_e;

  // Next receive word after capturing one bit in the chosen order.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur,
                                                 input logic bit_in,
                                                 input logic msb_first);
    if (msb_first) return {cur[DATA_W-2:0], bit_in};
    return {bit_in, cur[DATA_W-1:1]};
  endfunction

  // Transmit word after one bit has gone out; vacated positions fill with 1.
  function automatic logic [DATA_W-1:0] shift_out(input logic [DATA_W-1:0] cur,
                                                  input logic msb_first);
    if (msb_first) return {cur[DATA_W-2:0], 1'b1};
    return {1'b1, cur[DATA_W-1:1]};
  endfunction

  // System clocks per half bit period in master mode.
  function automatic int unsigned half_period(input int unsigned div_n,
                                              input int unsigned sel,
                                              input int unsigned step);
    return (div_n + 1) * (1 << (sel * step));
  endfunction
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int DIV_W    = 8,
  parameter int PRE_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_n,
  output logic             half_tick
);
  localparam int PW = 3 * PRE_STEP;

  logic [PW-1:0]    pre_cnt, pre_lim;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_tick;

  always_comb pre_lim = PW'((1 << (int'(src_sel) * PRE_STEP)) - 1);

  assign pre_tick  = run && (pre_cnt == pre_lim);
  assign half_tick = pre_tick && (div_cnt == div_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_tick) begin
      pre_cnt <= '0;
      div_cnt <= half_tick ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R3: the divider never passes the programmed count while running
  p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_cnt <= div_n));
  // R3: the prescaler never passes the selected limit
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_cnt <= pre_lim));
endmodule

// File: rtl/ssp_sync_edge.sv
module ssp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign q    = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter import ssp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              msb_first,
  input  logic              take,
  input  logic [DATA_W-1:0] take_data,
  input  logic              half_tick,
  input  logic              ext_rise,
  input  logic              ext_fall,
  input  logic              rxd,
  output logic              sclk,
  output logic              txd,
  output logic              busy,
  output logic              loaded,
  output logic              at_boundary,
  output logic              frame_done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);
  localparam logic [CW-1:0] FULL = CW'(DATA_W);

  logic [DATA_W-1:0] tsh, rsh;
  logic [CW-1:0]     cnt;
  logic              sclk_q, busy_q, loaded_q;
  logic              m_rise, m_fall, m_end, edge_rise, edge_fall;

  // Named bit-clock events shared by both roles
  assign m_rise    = master && busy_q && half_tick && !sclk_q;
  assign m_fall    = master && busy_q && half_tick && sclk_q && (cnt != FULL);
  assign m_end     = master && busy_q && half_tick && sclk_q && (cnt == FULL);
  assign edge_rise = m_rise | (!master & ext_rise);
  assign edge_fall = m_fall | (!master & ext_fall);

  assign frame_done  = edge_rise && (cnt == LAST);
  assign rx_word     = shift_in(rsh, rxd, msb_first);
  assign at_boundary = (cnt == '0) && !loaded_q;
  assign sclk        = sclk_q;
  assign busy        = busy_q;
  assign loaded      = loaded_q;
  assign txd         = loaded_q ? (msb_first ? tsh[DATA_W-1] : tsh[0]) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh      <= '1;
      rsh      <= '0;
      cnt      <= '0;
      sclk_q   <= 1'b1;
      busy_q   <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      if (take) begin
        tsh      <= take_data;
        loaded_q <= 1'b1;
        if (master) begin
          busy_q <= 1'b1;
          sclk_q <= 1'b0;
          cnt    <= '0;
        end
      end
      if (edge_fall) begin
        if (master) sclk_q <= 1'b0;
        if (cnt != '0 && loaded_q) tsh <= shift_out(tsh, msb_first);
      end
      if (edge_rise) begin
        if (master) sclk_q <= 1'b1;
        rsh <= rx_word;
        if (frame_done && !master) begin
          cnt      <= '0;
          loaded_q <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (m_end) begin
        busy_q   <= 1'b0;
        cnt      <= '0;
        loaded_q <= 1'b0;
      end
    end
  end

  // R3: the bit counter never exceeds one word
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  // R3: a master word always ends with the clock resting high
  p_end_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> sclk_q);
  // R9: a slave never raises the master busy state
  p_slave_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !$past(busy_q)) |-> !busy_q);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port import ssp_pkg::*; #(
  parameter int DIV_W       = 8,
  parameter int PRE_STEP    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sclk_i,
  output logic       sclk_o,
  output logic       sclk_oe,
  output logic       txd,
  input  logic       rxd,
  input  logic       cts_n,
  output logic       rts_n
);
  logic [7:0]        mode_q, ctl0_q;
  logic [DIV_W-1:0]  div_q;
  logic              te_q, re_q, oer_q, tx_full, rx_full;
  logic [DATA_W-1:0] txbuf_q, rxbuf_q;

  logic mode_ok, master, hs_en, rts_sel, cts_used, msb_first;
  logic cts_s, cts_rise_unused, cts_fall_unused;
  logic ck_s, ck_rise, ck_fall;
  logic half_tick, start, slave_take, take;
  logic sh_sclk, sh_txd, sh_busy, sh_loaded, sh_boundary, frame_done;
  logic [DATA_W-1:0] rx_word;
  logic wr_tx, rd_rx, wr_ctl1;

  assign mode_ok   = (mode_q[2:0] == 3'b001) && !mode_q[7];
  assign master    = !mode_q[3];
  assign hs_en     = !ctl0_q[4];
  assign rts_sel   = ctl0_q[2];
  assign cts_used  = hs_en && !rts_sel;
  assign msb_first = ctl0_q[5];

  assign wr_tx   = reg_wr && (reg_addr == A_TXB);
  assign wr_ctl1 = reg_wr && (reg_addr == A_CTL1);
  assign rd_rx   = reg_rd && (reg_addr == A_RXB);

  ssp_sync_edge #(.STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_n), .din(cts_n),
    .q(cts_s), .rise(cts_rise_unused), .fall(cts_fall_unused));

  ssp_sync_edge #(.STAGES(SYNC_STAGES)) u_ck (
    .clk(clk), .rst_n(rst_n), .din(sclk_i),
    .q(ck_s), .rise(ck_rise), .fall(ck_fall));

  ssp_clkgen #(.DIV_W(DIV_W), .PRE_STEP(PRE_STEP)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(sh_busy && master),
    .src_sel(ctl0_q[1:0]), .div_n(div_q), .half_tick(half_tick));

  assign start      = mode_ok && master && !sh_busy && te_q && tx_full &&
                      (!cts_used || !cts_s);
  assign slave_take = mode_ok && !master && te_q && tx_full && sh_boundary;
  assign take       = start || slave_take;

  ssp_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .master(master), .msb_first(msb_first),
    .take(take), .take_data(txbuf_q), .half_tick(half_tick),
    .ext_rise(ck_rise && mode_ok && ck_s), .ext_fall(ck_fall && mode_ok && !ck_s),
    .rxd(rxd), .sclk(sh_sclk), .txd(sh_txd), .busy(sh_busy),
    .loaded(sh_loaded), .at_boundary(sh_boundary), .frame_done(frame_done),
    .rx_word(rx_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ctl0_q  <= '0;
      div_q   <= '0;
      te_q    <= 1'b0;
      re_q    <= 1'b0;
      oer_q   <= 1'b0;
      tx_full <= 1'b0;
      rx_full <= 1'b0;
      txbuf_q <= '0;
      rxbuf_q <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_MODE: mode_q <= reg_wdata;
          A_CTL0: ctl0_q <= reg_wdata;
          A_DIV:  div_q  <= DIV_W'(reg_wdata);
          default: ;
        endcase
      end
      if (wr_ctl1) begin
        te_q <= reg_wdata[0];
        re_q <= reg_wdata[2];
      end
      // transmit buffer: a write wins over the move into the shift register
      if (wr_tx) begin
        txbuf_q <= reg_wdata;
        tx_full <= 1'b1;
      end else if (take) begin
        tx_full <= 1'b0;
      end
      // receive buffer and overrun
      if (frame_done && re_q && (!rx_full || rd_rx)) begin
        rxbuf_q <= rx_word;
        rx_full <= 1'b1;
      end else begin
        if (frame_done && re_q) oer_q <= 1'b1;
        else if (wr_ctl1 && !reg_wdata[2]) oer_q <= 1'b0;
        if (rd_rx) rx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_CTL0:  reg_rdata = ctl0_q;
      A_CTL1:  reg_rdata = {2'b00, !sh_loaded, oer_q, rx_full, re_q, !tx_full, te_q};
      A_DIV:   reg_rdata = 8'(div_q);
      A_TXB:   reg_rdata = txbuf_q;
      A_RXB:   reg_rdata = rxbuf_q;
      default: reg_rdata = '0;
    endcase
  end

  assign sclk_oe = mode_ok && master;
  assign sclk_o  = (mode_ok && master) ? sh_sclk : 1'b1;
  assign txd     = mode_ok ? sh_txd : 1'b1;
  assign rts_n   = !(mode_ok && hs_en && rts_sel && re_q && !rx_full);

  // R4: a master word begins only after clear-to-send was seen low when required
  p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sh_busy) && $past(cts_used)) |-> !$past(cts_s));
  // R3: an idle master keeps the bit clock high
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && !sh_busy) |-> sclk_o);
  // R7: ready-to-receive is never active while a word waits unread
  p_rts_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rts_n);
  // R8: overrun sets only on a word completing into a full buffer
  p_oer_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oer_q) |-> $past(frame_done && re_q && rx_full));
  // R10: a transmit-buffer write leaves the buffer full
  p_tx_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> tx_full);
  // R1: an invalid mode never starts a word
  p_mode_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ok && !sh_busy) |=> !sh_busy);
endmodule

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sclk_i = 1'b1, rxd = 1'b1, cts_n = 1'b1;
  logic       sclk_o, sclk_oe, txd, rts_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sync_serial_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .txd(txd),
    .rxd(rxd), .cts_n(cts_n), .rts_n(rts_n));

  // {sel[1:0], n[7:0], msb, tx[7:0], rx[7:0]}
  localparam int NV = 6;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 8'd0,   1'b0, 8'hA5, 8'h3C},
    {2'd1, 8'd2,   1'b1, 8'h81, 8'h7E},
    {2'd2, 8'd1,   1'b0, 8'h00, 8'hFF},
    {2'd0, 8'd3,   1'b1, 8'hFF, 8'h00},
    {2'd3, 8'd0,   1'b1, 8'h5A, 8'hC3},
    {2'd0, 8'd255, 1'b0, 8'h69, 8'h96}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_sclk(input logic level, input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (sclk_o === level) begin seen = 1'b1; break; end
    end
  endtask

  task automatic slave_frame(input logic [7:0] rx, output logic [7:0] got);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      sclk_i = 1'b0; rxd = rx[b];
      repeat (8) @(negedge clk);
      got[b] = txd;
      sclk_i = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    rd(3'd2, d);  check("R2 ctl1", d, 8'h22);
    rd(3'd5, d);  check("R2 rxbuf", d, 0);
    check("R2 sclk_o", sclk_o, 1);
    check("R2 sclk_oe", sclk_oe, 0);
    check("R2 txd", txd, 1);
    check("R2 rts_n", rts_n, 1);

    // R3 R5 R6 R4(ignored cts) R10: master table
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h05);
    for (int v = 0; v < NV; v++) begin
      logic [1:0] sel; logic [7:0] n, tx, rx; logic msb;
      int half, low;
      {sel, n, msb, tx, rx} = VEC[v];
      half = (int'(n) + 1) * (4 ** int'(sel));
      wr(3'd1, {2'b00, msb, 1'b1, 2'b00, sel});
      wr(3'd3, n);
      wr(3'd4, tx);
      check("R3 sclk_oe master", sclk_oe, 1);
      got = '0;
      for (int b = 0; b < 8; b++) begin
        int idx;
        idx = msb ? 7 - b : b;
        wait_sclk(1'b0, 40000, seen);
        if (b == 0) check("R4 start with cts ignored", seen, 1);
        rxd = rx[idx];
        low = 0;
        while (sclk_o === 1'b0 && low < 40000) begin
          low++;
          @(negedge clk);
        end
        got[idx] = txd;
        if (b == 0 || b == 7) check("R3 half period", low, half);
      end
      check("R5 transmitted word", got, tx);
      repeat (half + 4) @(negedge clk);
      check("R3 clock rests high", sclk_o, 1);
      rd(3'd2, d);  check("R6 RI set, R10 TI set", d, 8'h2F);
      rd(3'd5, d);  check("R6 R5 received word", d, rx);
      rd(3'd2, d);  check("R10 RI cleared by read", d[3], 0);
    end

    // R1 and R10: invalid modes hold data
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h10);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h03);
    wr(3'd4, 8'h11);
    rd(3'd2, d);  check("R10 TI cleared by write", d[1], 0);
    wait_sclk(1'b0, 50, seen);
    check("R1 mode 03 no word", seen, 0);
    wr(3'd0, 8'h81);
    wait_sclk(1'b0, 50, seen);
    check("R1 mode bit7 no word", seen, 0);
    check("R1 txd idle", txd, 1);
    rd(3'd2, d);  check("R1 data held", d[1], 0);
    wr(3'd0, 8'h71);
    wait_sclk(1'b0, 10, seen);
    check("R1 bits 4-6 ignored", seen, 1);
    repeat (40) @(negedge clk);
    rd(3'd2, d);  check("R1 word sent without receive", d, 8'h23);

    // R4: clear-to-send gating
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h22);
    wait_sclk(1'b0, 60, seen);
    check("R4 blocked by cts high", seen, 0);
    cts_n = 1'b0;
    wait_sclk(1'b0, 10, seen);
    check("R4 starts on cts low", seen, 1);
    repeat (40) @(negedge clk);
    cts_n = 1'b1;

    // R9 R7 R8 R11: slave mode
    wr(3'd2, 8'h05);
    wr(3'd1, 8'h07);
    wr(3'd0, 8'h09);
    check("R9 sclk_oe slave", sclk_oe, 0);
    check("R7 rts low ready", rts_n, 0);
    wr(3'd4, 8'hA5);
    repeat (3) @(negedge clk);
    rd(3'd2, d);  check("R10 TI after slave load", d, 8'h07);
    slave_frame(8'h3C, got);
    check("R9 slave transmitted", got, 8'hA5);
    rd(3'd2, d);  check("R9 slave RI", d, 8'h2F);
    check("R7 rts high when full", rts_n, 1);
    slave_frame(8'h99, got);
    check("R9 idle txd", got, 8'hFF);
    rd(3'd2, d);  check("R8 overrun set", d, 8'h3F);
    rd(3'd5, d);  check("R8 buffer kept", d, 8'h3C);
    @(negedge clk);
    check("R7 rts low after read", rts_n, 0);
    wr(3'd2, 8'h01);
    rd(3'd2, d);  check("R11 overrun cleared", d, 8'h23);
    check("R7 rts high without RE", rts_n, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule